// File: doc/BRIEF.md
# Comparator Output Conditioner with Shutdown Request

This block is the digital back end that sits behind an analog comparator. It takes the comparator's raw decision bit, gates it with an enable, applies a programmable inversion and presents the result as the architectural output bit. A copy of that output can optionally be re-timed to the falling edge of a timer clock before it is handed to other peripherals.

A change-detection path supports interrupts. A capture register takes a snapshot of the output whenever software reads the control register during the third processor phase. A sample register follows the output on the first processor phase (and on every cycle while the core sleeps). The interrupt-flag set output is asserted whenever the sampled output and the snapshot disagree.

The shutdown request for a PWM auto-shutdown input is decoded straight from the conditioned output level, compared against a programmable active level. It never passes through the interrupt path. A register read therefore cannot cancel a shutdown, and the request is not delayed by phase sampling. All state is in one clock domain. The phase strobes and the timer clock are level inputs sampled on `clk_i`.

Top module: `cmp_cond_top`

## Requirements
- R1: While `enable_i` is 0 the raw bit is treated as 0, so `out_o` equals `polarity_i` whatever `raw_i` is.
- R2: `out_o` is combinationally `(raw_i & enable_i) ^ polarity_i`.
- R3: The capture register loads `out_o` on a rising `clk_i` edge where `rd_strobe_i` and `q3_i` are both 1. On any other edge it holds, so a read strobe without `q3_i` has no effect.
- R4: The sample register loads `out_o` on a rising edge where `q1_i` is 1. Otherwise it holds. `flag_set_o` is 1 exactly when the sample and capture registers differ.
- R5: While `sleep_i` is 1, the sample register loads `out_o` on every edge regardless of `q1_i`.
- R6: The sync register loads `out_o` on a rising edge where the registered previous `tmr_clk_i` is 1 and the present `tmr_clk_i` is 0. `sync_out_o` is that register when `sync_sel_i` is 1, and `out_o` when `sync_sel_i` is 0.
- R7: `shutdown_o` is combinationally 1 when `out_o` equals `sd_level_i`. It does not depend on `rd_strobe_i`, the phase strobes or `flag_set_o`.
- R8: While `rst_ni` is 0, `shutdown_o` is 0. The capture, sample, sync and previous-timer-clock registers are all cleared to 0, so `flag_set_o` is 0 and a selected `sync_out_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raw_i | input | 1 | Raw comparator decision |
| enable_i | input | 1 | Comparator enable |
| polarity_i | input | 1 | Output inversion select |
| sync_sel_i | input | 1 | 1 selects the timer-synchronised copy on sync_out_o |
| rd_strobe_i | input | 1 | Control register read strobe |
| q1_i | input | 1 | Processor phase 1 strobe |
| q3_i | input | 1 | Processor phase 3 strobe |
| sleep_i | input | 1 | Core sleep indication |
| tmr_clk_i | input | 1 | Timer clock level, sampled on clk_i |
| sd_level_i | input | 1 | Output level that requests shutdown |
| out_o | output | 1 | Conditioned output bit |
| sync_out_o | output | 1 | Output copy for other peripherals |
| flag_set_o | output | 1 | Interrupt flag set request (mismatch) |
| shutdown_o | output | 1 | PWM auto-shutdown request |

## Verification
The assertions take for granted that every input is synchronous to `clk_i`. They also assume that `tmr_clk_i` is slow enough that one level lasts at least one `clk_i` cycle, so that each falling edge is seen as a single-cycle 1-to-0 step. The stimulus changes inputs only on the falling edge of `clk_i`. It derives `q1_i` and `q3_i` from a rotating four-phase count, with random extra pulses. It toggles `tmr_clk_i` at random, and it mixes in directed cases: reads outside phase 3, sleep with `q1_i` low, and shutdown while reading.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
  typedef enum logic {
    OUT_DIRECT     = 1'b0,
    OUT_TIMER_SYNC = 1'b1
  } out_sel_e;
endpackage

// File: rtl/cmp_polarity.sv
module cmp_polarity (
  input  logic raw_i,
  input  logic enable_i,
  input  logic polarity_i,
  output logic out_o
);
  logic gated;
  always_comb begin
    gated = raw_i & enable_i;
    out_o = gated ^ polarity_i;
  end
endmodule

// File: rtl/cmp_mismatch.sv
module cmp_mismatch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic rd_strobe_i,
  input  logic q1_i,
  input  logic q3_i,
  input  logic sleep_i,
  output logic flag_set_o
);
  logic cap_q, smp_q;
  logic cap_en, smp_en;

  assign cap_en = rd_strobe_i & q3_i;
  assign smp_en = q1_i | sleep_i;   // sleep keeps the sampler transparent

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else if (cap_en) cap_q <= d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= 1'b0;
    else if (smp_en) smp_q <= d_i;
  end

  assign flag_set_o = smp_q ^ cap_q;

  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && q3_i) |=> (cap_q == $past(d_i)));
  assert_capture_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_strobe_i && q3_i) |=> $stable(cap_q));
  assert_sample_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(q1_i || sleep_i) |=> $stable(smp_q));
  assert_sleep_sample_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (smp_q == $past(d_i)));
endmodule

// File: rtl/cmp_sync.sv
module cmp_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic tmr_clk_i,
  output logic q_o
);
  logic tmr_d_q, fall;

  assign fall = tmr_d_q & ~tmr_clk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_d_q <= 1'b0;
      q_o     <= 1'b0;
    end else begin
      tmr_d_q <= tmr_clk_i;
      if (fall) q_o <= d_i;
    end
  end

  assert_sync_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tmr_clk_i) && !tmr_clk_i) |=> (q_o == $past(d_i)));
  assert_sync_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($past(tmr_clk_i) && !tmr_clk_i) |=> $stable(q_o));
endmodule

// File: rtl/cmp_cond_top.sv
module cmp_cond_top
  import cmp_cond_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic enable_i,
  input  logic polarity_i,
  input  logic sync_sel_i,
  input  logic rd_strobe_i,
  input  logic q1_i,
  input  logic q3_i,
  input  logic sleep_i,
  input  logic tmr_clk_i,
  input  logic sd_level_i,
  output logic out_o,
  output logic sync_out_o,
  output logic flag_set_o,
  output logic shutdown_o
);
  logic     sync_q;
  out_sel_e sel;

  cmp_polarity u_pol (
    .raw_i      (raw_i),
    .enable_i   (enable_i),
    .polarity_i (polarity_i),
    .out_o      (out_o)
  );

  cmp_mismatch u_mm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .d_i         (out_o),
    .rd_strobe_i (rd_strobe_i),
    .q1_i        (q1_i),
    .q3_i        (q3_i),
    .sleep_i     (sleep_i),
    .flag_set_o  (flag_set_o)
  );

  cmp_sync u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       (out_o),
    .tmr_clk_i (tmr_clk_i),
    .q_o       (sync_q)
  );

  assign sel        = out_sel_e'(sync_sel_i);
  assign sync_out_o = (sel == OUT_TIMER_SYNC) ? sync_q : out_o;
  // taken from the output level, never from the flag path
  assign shutdown_o = rst_ni & ~(out_o ^ sd_level_i);

  assert_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (out_o == polarity_i));
  assert_sd_indep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(out_o) && $stable(sd_level_i)) |-> $stable(shutdown_o));
  always_comb begin
    if (rst_ni == 1'b0) begin
      assert_reset_sd_R8: assert (shutdown_o == 1'b0);
    end
  end
endmodule

// File: tb/cmp_cond_top_tb.sv
module cmp_cond_top_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic raw_i = 0, enable_i = 0, polarity_i = 0, sync_sel_i = 0;
  logic rd_strobe_i = 0, q1_i = 0, q3_i = 0, sleep_i = 0;
  logic tmr_clk_i = 0, sd_level_i = 0;
  logic out_o, sync_out_o, flag_set_o, shutdown_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic m_cap = 0, m_smp = 0, m_sync = 0, m_tprev = 0;

  always #5 clk = ~clk;

  cmp_cond_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .raw_i(raw_i), .enable_i(enable_i),
    .polarity_i(polarity_i), .sync_sel_i(sync_sel_i), .rd_strobe_i(rd_strobe_i),
    .q1_i(q1_i), .q3_i(q3_i), .sleep_i(sleep_i), .tmr_clk_i(tmr_clk_i),
    .sd_level_i(sd_level_i), .out_o(out_o), .sync_out_o(sync_out_o),
    .flag_set_o(flag_set_o), .shutdown_o(shutdown_o)
  );

  function automatic logic exp_out();
    return (raw_i & enable_i) ^ polarity_i;
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // at negedge with inputs applied: check, then advance model over posedge
  task automatic cycle();
    logic e;
    #1;
    e = exp_out();
    chk(out_o, e, enable_i ? "R2" : "R1");
    chk(flag_set_o, m_smp ^ m_cap, "R4");
    chk(sync_out_o, sync_sel_i ? m_sync : e, "R6");
    chk(shutdown_o, e == sd_level_i, "R7");
    @(posedge clk);
    if (rd_strobe_i && q3_i) m_cap = e;
    if (q1_i || sleep_i) m_smp = e;
    if (m_tprev && !tmr_clk_i) m_sync = e;
    m_tprev = tmr_clk_i;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned ph;
    void'($urandom(32'h5eed_c0de));
    // R8: reset state with output matching shutdown level
    raw_i = 1; enable_i = 1; sd_level_i = 1; sync_sel_i = 1;
    q1_i = 1; q3_i = 1; rd_strobe_i = 1; tmr_clk_i = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(shutdown_o, 1'b0, "R8");
    chk(flag_set_o, 1'b0, "R8");
    chk(sync_out_o, 1'b0, "R8");
    chk(out_o, 1'b1, "R2");
    @(negedge clk);
    q1_i = 0; q3_i = 0; rd_strobe_i = 0; tmr_clk_i = 0;
    rst_ni = 1;

    // R1: disabled forces raw to 0
    enable_i = 0; raw_i = 1; polarity_i = 0; cycle();
    polarity_i = 1; cycle();

    // R3: read without q3 does not capture; flag from q1 sample stays visible
    enable_i = 1; raw_i = 1; polarity_i = 0; q1_i = 1; cycle();
    q1_i = 0; rd_strobe_i = 1; q3_i = 0; cycle();
    #1 chk(flag_set_o, 1'b1, "R3 read outside q3 ignored");
    rd_strobe_i = 1; q3_i = 1; #0 cycle();
    rd_strobe_i = 0; q3_i = 0;
    #1 chk(flag_set_o, 1'b0, "R3 capture clears mismatch");

    // R5: sleep samples without q1
    raw_i = 0; sleep_i = 1; cycle();
    #1 chk(flag_set_o, 1'b1, "R5 sleep sampling");
    sleep_i = 0; #0 cycle();

    // R7: shutdown follows level during a read, flag irrelevant
    sd_level_i = 0; rd_strobe_i = 1; q3_i = 1; cycle();
    #1 chk(shutdown_o, 1'b1, "R7 shutdown during read");
    rd_strobe_i = 0; q3_i = 0;

    // R6: timer falling edge loads sync copy
    sync_sel_i = 1; tmr_clk_i = 1; raw_i = 1; cycle();
    tmr_clk_i = 0; cycle();
    #1 chk(sync_out_o, 1'b1, "R6 sync after falling edge");
    raw_i = 0; #0 cycle();
    #1 chk(sync_out_o, 1'b1, "R6 sync holds");
    @(negedge clk);

    // random mix with rotating phases
    ph = 0;
    for (int i = 0; i < 3000; i++) begin
      raw_i       = $urandom % 2;
      enable_i    = ($urandom % 4) != 0;
      polarity_i  = $urandom % 2;
      sync_sel_i  = $urandom % 2;
      sd_level_i  = $urandom % 2;
      sleep_i     = ($urandom % 8) == 0;
      rd_strobe_i = ($urandom % 3) == 0;
      q1_i        = (ph == 0) || (($urandom % 16) == 0);
      q3_i        = (ph == 2) || (($urandom % 16) == 0);
      if (($urandom % 3) == 0) tmr_clk_i = ~tmr_clk_i;
      ph = (ph + 1) % 4;
      cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule